// File: doc/BRIEF.md
# Byte-Wide Buffer DMA Engine

This block moves data between an 8-bit storage-bus controller and a 64 KB local buffer that is organised as 32-bit words. The controller runs in a one-request-per-byte mode. For each request the engine makes one single-byte buffer access, answers with one acknowledge, then advances its address pointer and its byte counter. The host loads a 16-bit start address and a 16-bit byte count over a small register port. A direction input chooses the flow: send moves bytes from the buffer to the controller, and receive moves bytes from the controller into the buffer.

Every buffer access goes through a request/grant handshake with a local arbiter. The arbiter ranks the engine below network DMA and above host bus traffic, and the engine waits for as long as the grant is withheld. The end-of-process flag is raised only in send direction. Its condition is that the counter has already reached zero when the next byte is served. A completed send of N bytes therefore takes N+1 transfers. It leaves the counter at 0xFFFF and the address at start+N+1. An active-low enable input clears any pending request and keeps the engine idle.

Top module: `byte_dma_engine`

## Requirements
- R1: Writing with `regSel`=0 loads the address register and writing with `regSel`=1 loads the counter. Both values are visible on `addrOut`/`countOut` on the cycle after the write, and both are 0 after reset.
- R2: In receive direction (`ctlSend`=0), each served request writes `dataFromCtl` into the buffer. The write goes to word `addr[15:2]` with a single byte enable. Byte lane `addr[1:0]`=0 is bits 31:24, and the lanes step down to lane 3 at bits 7:0.
- R3: In send direction (`ctlSend`=1), each served request returns, on `dataToCtl`, the byte of the word at `addr[15:2]` in the lane chosen by `addr[1:0]`, using the same lane order as R2. The byte is valid while `dack` is high.
- R4: Each served request increments the address by one and decrements the counter by one.
- R5: `eop` goes high only together with `dack` and only in send direction. In send direction it is high exactly when the counter read 0 at the moment that byte was moved. It never goes high in receive direction.
- R6: A send loaded with count N completes on its (N+1)th transfer, with `eop` high. Afterwards the counter reads 0xFFFF and the address reads start+N+1.
- R7: While `busGrant` is low, `busReq` stays high and `bufWordAddr` holds steady. No `dack` is given and the counter does not change.
- R8: While `ctlResetN` is low, `drq` is ignored and no `busReq` or `dack` is produced. Dropping `ctlResetN` while a request is pending removes `busReq` by the next cycle without moving a byte.
- R9: The address wraps from 0xFFFF to 0x0000.
- R10: A `drq` held high produces only one `dack`. The next transfer needs `drq` to go low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Host register write strobe |
| regSel | input | 1 | 0 selects address register, 1 selects counter |
| regWrData | input | 16 | Host write data |
| addrOut | output | 16 | Current address register |
| countOut | output | 16 | Current byte counter |
| ctlSend | input | 1 | Direction: 1 buffer to controller, 0 controller to buffer |
| ctlResetN | input | 1 | Active-low engine hold/clear |
| drq | input | 1 | Per-byte request from the controller |
| dack | output | 1 | Per-byte acknowledge |
| eop | output | 1 | End of transfer, send direction only |
| dataFromCtl | input | 8 | Byte from controller (receive) |
| dataToCtl | output | 8 | Byte to controller (send) |
| busReq | output | 1 | Local buffer bus request |
| busGrant | input | 1 | Local buffer bus grant |
| bufWordAddr | output | 14 | Buffer word address |
| bufWrite | output | 1 | Buffer write enable (valid with busReq) |
| bufByteEn | output | 4 | Buffer byte enables |
| bufWrData | output | 32 | Buffer write data (byte replicated) |
| bufRdData | input | 32 | Buffer read data |

## Verification
The bench targets the off-by-one end of a send. If `eop` were tied to the count reaching zero instead of being zero, it would fire one transfer early and the final counter would read 0 instead of 0xFFFF. Lane order is checked against known words in both directions, so a reversed lane map would show up as swapped bytes. The bench also withholds the grant, holds `drq` high, wraps the address past 0xFFFF and drops the enable while a request is pending. A design that skips the grant wait, acknowledges a held request twice, or leaves a stale request behind the enable would be seen on `dack`, `busReq` and the counter.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_LOW  = 2'd3
  } dmaState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;   // buffer access granted this cycle: move byte, step pointers
    logic ackPhase;  // acknowledge cycle toward the controller
  } dmaStrobe_t;
endpackage

// File: rtl/bdma_ctrl.sv
module bdma_ctrl
  import bdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlResetN,
  input  logic       drq,
  input  logic       busGrant,
  output logic       busReq,
  output logic       dack,
  output dmaStrobe_t strobe
);
  dmaState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (drq) stateNext = ST_REQ;
      ST_REQ:  if (busGrant) stateNext = ST_ACK;
      ST_ACK:  stateNext = ST_LOW;
      ST_LOW:  if (!drq) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    if (!ctlResetN) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busReq          = (state == ST_REQ) && ctlResetN;
  assign dack            = (state == ST_ACK);
  assign strobe.capture  = busReq && busGrant;
  assign strobe.ackPhase = dack;

  // R7: acknowledge only follows a granted access
  p_ack_after_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dack) |-> $past(busReq && busGrant));
  // R7: request is held until granted or cancelled
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant && ctlResetN) |=> (busReq || !ctlResetN));
  // R8: hold input clears the engine
  p_idle_in_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctlResetN |=> (!busReq && !dack));
  // R10: acknowledge is a single-cycle pulse per request
  p_one_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    dack |=> !dack);
endmodule

// File: rtl/bdma_path.sv
module bdma_path
  import bdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES),
  localparam int WORD_W = BYTE_W * LANES,
  localparam int WADR_W = ADDR_W - LANE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              sendMode,
  input  dmaStrobe_t        strobe,
  input  logic [BYTE_W-1:0] dataFromCtl,
  input  logic [WORD_W-1:0] bufRdData,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] countOut,
  output logic [BYTE_W-1:0] dataToCtl,
  output logic              eop,
  output logic [WADR_W-1:0] bufWordAddr,
  output logic [LANES-1:0]  bufByteEn,
  output logic [WORD_W-1:0] bufWrData
);
  logic [ADDR_W-1:0] addrReg, countReg;
  logic [BYTE_W-1:0] rdLatch;
  logic              eopFlag;
  logic [LANE_W-1:0] lane;
  logic [BYTE_W-1:0] laneBytes [LANES];
  logic              loadAddr, loadCount;

  assign lane        = addrReg[LANE_W-1:0];
  assign bufWordAddr = addrReg[ADDR_W-1:LANE_W];
  assign loadAddr    = regWrEn && !regSel;
  assign loadCount   = regWrEn && regSel;

  // Lane 0 is the most significant byte of the word
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign bufByteEn[LANES-1-g]          = (lane == LANE_W'(g));
    assign bufWrData[g*BYTE_W +: BYTE_W] = dataFromCtl;
    assign laneBytes[g]                  = bufRdData[(LANES-1-g)*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      countReg <= '0;
      rdLatch  <= '0;
      eopFlag  <= 1'b0;
    end else begin
      if (loadAddr)              addrReg  <= regWrData;
      else if (strobe.capture)   addrReg  <= addrReg + 1'b1;
      if (loadCount)             countReg <= regWrData;
      else if (strobe.capture)   countReg <= countReg - 1'b1;
      if (strobe.capture) begin
        rdLatch <= laneBytes[lane];
        eopFlag <= sendMode && (countReg == '0);
      end
    end
  end

  assign addrOut   = addrReg;
  assign countOut  = countReg;
  assign dataToCtl = rdLatch;
  assign eop       = eopFlag && strobe.ackPhase;

  // R4: pointer and counter step once per moved byte
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !loadAddr) |=> (addrReg == $past(addrReg) + 1'b1));
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !loadCount) |=> (countReg == $past(countReg) - 1'b1));
  // R5: end flag only in send direction
  p_eop_send_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    eop |-> $past(sendMode));
  // R2: exactly one byte lane enabled
  p_one_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bufByteEn) && ($countones(bufByteEn) == 1));
endmodule

// File: rtl/byte_dma_engine.sv
module byte_dma_engine
  import bdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES),
  localparam int WORD_W = BYTE_W * LANES,
  localparam int WADR_W = ADDR_W - LANE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] countOut,
  input  logic              ctlSend,
  input  logic              ctlResetN,
  input  logic              drq,
  output logic              dack,
  output logic              eop,
  input  logic [BYTE_W-1:0] dataFromCtl,
  output logic [BYTE_W-1:0] dataToCtl,
  output logic              busReq,
  input  logic              busGrant,
  output logic [WADR_W-1:0] bufWordAddr,
  output logic              bufWrite,
  output logic [LANES-1:0]  bufByteEn,
  output logic [WORD_W-1:0] bufWrData,
  input  logic [WORD_W-1:0] bufRdData
);
  dmaStrobe_t strobe;

  bdma_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlResetN (ctlResetN),
    .drq       (drq),
    .busGrant  (busGrant),
    .busReq    (busReq),
    .dack      (dack),
    .strobe    (strobe)
  );

  bdma_path #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .regWrData   (regWrData),
    .sendMode    (ctlSend),
    .strobe      (strobe),
    .dataFromCtl (dataFromCtl),
    .bufRdData   (bufRdData),
    .addrOut     (addrOut),
    .countOut    (countOut),
    .dataToCtl   (dataToCtl),
    .eop         (eop),
    .bufWordAddr (bufWordAddr),
    .bufByteEn   (bufByteEn),
    .bufWrData   (bufWrData)
  );

  assign bufWrite = busReq && !ctlSend;
endmodule

// File: tb/tb_byte_dma_engine.sv
`timescale 1ns/1ps
module tb_byte_dma_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] addrOut, countOut;
  logic        ctlSend = 1'b0, ctlResetN = 1'b1, drq = 1'b0;
  logic        dack, eop;
  logic [7:0]  dataFromCtl = '0, dataToCtl;
  logic        busReq, busGrant, bufWrite;
  logic        blockGrant = 1'b0;
  logic [13:0] bufWordAddr;
  logic [3:0]  bufByteEn;
  logic [31:0] bufWrData, bufRdData;
  logic [31:0] mem [256];

  int checks = 0, fails = 0;
  logic lastEop;
  logic [7:0] lastData;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_dma_engine dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .addrOut(addrOut), .countOut(countOut),
    .ctlSend(ctlSend), .ctlResetN(ctlResetN), .drq(drq), .dack(dack),
    .eop(eop), .dataFromCtl(dataFromCtl), .dataToCtl(dataToCtl),
    .busReq(busReq), .busGrant(busGrant), .bufWordAddr(bufWordAddr),
    .bufWrite(bufWrite), .bufByteEn(bufByteEn), .bufWrData(bufWrData),
    .bufRdData(bufRdData)
  );

  // Buffer and arbiter model
  assign busGrant  = busReq && !blockGrant;
  assign bufRdData = mem[bufWordAddr[7:0]];
  always @(posedge clk) begin
    if (busReq && busGrant && bufWrite)
      for (int b = 0; b < 4; b++)
        if (bufByteEn[b]) mem[bufWordAddr[7:0]][b*8 +: 8] <= bufWrData[b*8 +: 8];
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(logic sel, logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // One request/acknowledge exchange; records eop and data at dack
  task automatic doByte(logic [7:0] wrByte);
    int t = 0;
    @(negedge clk);
    dataFromCtl = wrByte;
    drq = 1'b1;
    while (dack !== 1'b1 && t < 50) begin
      @(negedge clk);
      t++;
    end
    lastEop  = eop;
    lastData = dataToCtl;
    drq = 1'b0;
    cyc(2);
  endtask

  task automatic testReset();
    check("R1 reset addr", addrOut, 0);
    check("R1 reset count", countOut, 0);
    check("R8 reset busReq", busReq, 0);
    check("R10 reset dack", dack, 0);
    writeReg(1'b0, 16'h1234);
    writeReg(1'b1, 16'hBEEF);
    check("R1 addr load", addrOut, 16'h1234);
    check("R1 count load", countOut, 16'hBEEF);
  endtask

  task automatic testSend();
    ctlSend = 1'b1;
    writeReg(1'b0, 16'h0010);
    writeReg(1'b1, 16'd3);
    doByte(8'h00);
    check("R3 send lane0", lastData, 8'hA1);
    check("R5 no early eop", lastEop, 0);
    check("R4 addr step", addrOut, 16'h0011);
    check("R4 count step", countOut, 16'd2);
    doByte(8'h00);
    check("R3 send lane1", lastData, 8'hB2);
    doByte(8'h00);
    check("R3 send lane2", lastData, 8'hC3);
    check("R5 no eop at count reaching 0", lastEop, 0);
    doByte(8'h00);
    check("R3 send lane3", lastData, 8'hD4);
    check("R6 eop on extra transfer", lastEop, 1);
    check("R6 final count", countOut, 16'hFFFF);
    check("R6 final addr", addrOut, 16'h0014);
  endtask

  task automatic testReceive();
    ctlSend = 1'b0;
    writeReg(1'b0, 16'h0020);
    writeReg(1'b1, 16'd2);
    doByte(8'h11); check("R5 recv no eop", lastEop, 0);
    doByte(8'h22); check("R5 recv no eop", lastEop, 0);
    doByte(8'h33); check("R5 recv no eop past zero", lastEop, 0);
    check("R2 recv lanes", mem[8], 32'h112233FF);
    check("R4 recv count", countOut, 16'hFFFF);
    check("R4 recv addr", addrOut, 16'h0023);
  endtask

  task automatic testWrap();
    ctlSend = 1'b0;
    writeReg(1'b0, 16'hFFFF);
    writeReg(1'b1, 16'd5);
    doByte(8'h5A);
    check("R9 wrap addr", addrOut, 16'h0000);
    check("R2 last lane", mem[255], 32'h0000005A);
    doByte(8'h6B);
    check("R2 lane0 after wrap", mem[0], 32'h6B000000);
  endtask

  task automatic testGrantWait();
    logic [13:0] wa;
    ctlSend = 1'b1;
    writeReg(1'b0, 16'h0040);
    writeReg(1'b1, 16'd7);
    blockGrant = 1'b1;
    @(negedge clk);
    drq = 1'b1;
    cyc(2);
    wa = bufWordAddr;
    for (int i = 0; i < 5; i++) begin
      check("R7 req held", busReq, 1);
      check("R7 no dack", dack, 0);
      check("R7 addr stable", bufWordAddr, wa);
      cyc(1);
    end
    check("R7 count unchanged", countOut, 16'd7);
    blockGrant = 1'b0;
    cyc(1);
    check("R7 dack after grant", dack, 1);
    check("R3 grant-late data", dataToCtl, 8'h5C);
    drq = 1'b0;
    cyc(2);
    check("R7 count after", countOut, 16'd6);
  endtask

  task automatic testHold();
    ctlSend = 1'b0;
    writeReg(1'b0, 16'h0080);
    writeReg(1'b1, 16'd4);
    ctlResetN = 1'b0;
    @(negedge clk);
    drq = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check("R8 no req in hold", busReq, 0);
      check("R8 no dack in hold", dack, 0);
      cyc(1);
    end
    drq = 1'b0;
    ctlResetN = 1'b1;
    cyc(2);
    check("R8 count untouched", countOut, 16'd4);
    blockGrant = 1'b1;
    drq = 1'b1;
    cyc(2);
    check("R8 pending req", busReq, 1);
    ctlResetN = 1'b0;
    cyc(1);
    check("R8 pending cleared", busReq, 0);
    drq = 1'b0;
    blockGrant = 1'b0;
    ctlResetN = 1'b1;
    cyc(3);
    check("R8 no late req", busReq, 0);
    check("R8 addr untouched", addrOut, 16'h0080);
    check("R8 buffer untouched", mem[32], 32'h0);
  endtask

  task automatic testHeldDrq();
    int acks = 0;
    ctlSend = 1'b1;
    writeReg(1'b0, 16'h0010);
    writeReg(1'b1, 16'd9);
    @(negedge clk);
    drq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (dack) acks++;
    end
    drq = 1'b0;
    cyc(2);
    check("R10 one ack per held drq", acks, 1);
    check("R10 one step", countOut, 16'd8);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[4]  = 32'hA1B2C3D4;
    mem[8]  = 32'hFFFFFFFF;
    mem[16] = 32'h5C5D5E5F;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    testReset();
    testSend();
    testReceive();
    testWrap();
    testGrantWait();
    testHold();
    testHeldDrq();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule